// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath that handles a small 32-bit load/store instruction set. It holds an eleven-state machine. Each state drives the select and enable lines of the datapath: the program counter, the shared instruction/data memory port, the instruction register, the register file and the ALU. The instruction register feeds the opcode and function fields back into the block. The ALU feeds back its zero flag, its sign bit and an overflow flag. The control outputs are combinational in the current state and the decoded instruction. The state moves on every rising clock edge.

An instruction passes through fetch, then decode, then one of four paths: ALU execute and writeback, address computation and memory access, a single control-transfer cycle, or an exception state. ALU overflow on a trapping arithmetic instruction is diverted to an exception state. An opcode or function code that the block does not know is diverted to a second exception state. Each exception state saves the PC and loads a fixed handler address. The datapath itself is outside this block.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low at a rising edge the machine enters the fetch state. During and right after reset, the outputs show fetch controls: `pc_wr`=1, `pc_src`=3, `mem_rd`=1, `ir_wr`=1, `reg_wr`=0, `mem_wr`=0.
- R2: Fetch (state 0) drives `inst_data`=0, `mem_rd`=1, `ir_wr`=1, `alu_x_sel`=0, `alu_y_sel`=0 (constant 4), `add_sub`=0, `fn_class`=2 (arithmetic), `pc_src`=3 (ALU output) and `pc_wr`=1. The next state is always decode.
- R3: Decode (state 1) drives `alu_x_sel`=0, `alu_y_sel`=3 (immediate times 4), add, `fn_class`=2. It dispatches ALU instructions to state 7, lw (35) and sw (43) to state 2, transfers to state 5, and anything else to state 10.
- R4: Memory path. State 2 adds base and offset (`alu_x_sel`=1, `alu_y_sel`=2, add, `fn_class`=2). A load then goes through state 3 (`inst_data`=1, `mem_rd`=1) and state 4 (`reg_wr`=1, `reg_dst`=0 (rt), `reg_in_src`=0 (data register)). A store goes through state 6 (`inst_data`=1, `mem_wr`=1).
- R5: Transfer state 5 drives `alu_x_sel`=1, `alu_y_sel`=1, subtract, `fn_class`=2. j (2) gives `pc_src`=0 and `jmp_sel`=0. jal (3) does the same and also writes register 31 with the PC (`reg_dst`=2, `reg_in_src`=2). jr (opcode 0, funct 8) gives `pc_src`=1. syscall (opcode 0, funct 12) gives `pc_src`=0 and `jmp_sel`=1. For beq (4), bne (5) and bltz (1), `pc_src`=2 and `pc_wr` follows `alu_zero`, `!alu_zero` and `alu_sign` respectively. The next state is fetch.
- R6: Counting fetch as the first cycle, an instruction takes 4 cycles for an ALU operation, 5 for lw, 4 for sw and 3 for a branch or jump. An undefined instruction takes 3 cycles.
- R7: Execute state 7 drives `alu_x_sel`=1. `alu_y_sel` is 1 for opcode 0 and 2 for an immediate form. `add_sub`=1 for sub, slt and slti. `fn_class` is 0 for lui (15), 1 for slt/slti (funct 42 / opcode 10), 2 for add/sub/addi (funct 32/34, opcode 8) and 3 for the logic group. `logic_fn` is 0 for and/andi (36/12), 1 for or/ori (37/13), 2 for xor/xori (38/14) and 3 for nor (39).
- R8: Writeback state 8 drives `reg_wr`=1 and `reg_in_src`=1 (z register). `reg_dst` is 1 (rd) for opcode 0 and 0 (rt) for the immediate forms. The next state is fetch.
- R9: In state 7, `alu_ovf`=1 sends add, sub and addi to state 9 instead of state 8; other ALU instructions ignore it. States 9 and 10 drive `epc_wr`=1, `pc_wr`=1, `pc_src`=0 and `jmp_sel`=2 (handler address), then return to fetch.
- R10: An undefined opcode, or opcode 0 with an undefined function code, goes from decode to state 10 and does not write a register or memory.
- R11: `reg_wr` is asserted only in states 4 and 8 and for jal in state 5. `mem_wr` is asserted only in state 6. `mem_rd` and `mem_wr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| funct | input | 6 | Function field from the instruction register |
| alu_zero | input | 1 | ALU result is zero |
| alu_sign | input | 1 | ALU result sign bit |
| alu_ovf | input | 1 | ALU arithmetic overflow |
| pc_wr | output | 1 | PC load enable |
| pc_src | output | 2 | PC source: 0 jump address, 1 x register, 2 z register, 3 ALU output |
| jmp_sel | output | 2 | Jump address: 0 jump target, 1 syscall entry, 2 exception handler |
| inst_data | output | 1 | Memory address: 0 PC, 1 z register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 2 | Destination: 0 rt, 1 rd, 2 register 31 |
| reg_in_src | output | 2 | Write data: 0 data register, 1 z register, 2 PC |
| alu_x_sel | output | 1 | ALU x operand: 0 PC, 1 x register |
| alu_y_sel | output | 2 | ALU y operand: 0 four, 1 y register, 2 immediate, 3 immediate times 4 |
| add_sub | output | 1 | Adder: 0 add, 1 subtract |
| logic_fn | output | 2 | Logic unit: 0 and, 1 or, 2 xor, 3 nor |
| fn_class | output | 2 | ALU result class: 0 lui, 1 set-less, 2 arithmetic, 3 logic |
| epc_wr | output | 1 | Save PC into the exception PC register |

## Verification
Every control output depends only on the current state and the instruction fields, so its value is due in the same cycle as the inputs that select it. The state advances exactly one rising edge later. The bench changes the instruction fields and ALU flags on the falling edge, compares all outputs one time unit later against a behavioural model that is in the same state, and then moves the model on by one state when the edge comes. The per-instruction cycle count and the counts of register and memory writes are checked when the model returns to fetch. Those counts bound every result of an instruction to its own window.

// File: rtl/mc_ctrl_pkg.sv
// Package: shared widths, state numbering, opcode/function constants,
// output encodings and the decoded-instruction record for the control unit.
// Assumes a 6-bit opcode and a 6-bit function field.
package mc_ctrl_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ST_W  = 4;
    localparam int SEL_W = 2;

    // State numbers are fixed; the state sequence is part of the behaviour.
    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_MRD    = 4'd3,
        ST_LDWB   = 4'd4,
        ST_XFER   = 4'd5,
        ST_MWR    = 4'd6,
        ST_EXEC   = 4'd7,
        ST_ALUWB  = 4'd8,
        ST_OVFX   = 4'd9,
        ST_BADX   = 4'd10
    } state_e;

    typedef enum logic [1:0] {
        PATH_ALU,
        PATH_MEM,
        PATH_XFER,
        PATH_BAD
    } path_e;

    typedef enum logic [2:0] {
        XF_J,
        XF_JAL,
        XF_JR,
        XF_SYS,
        XF_BEQ,
        XF_BNE,
        XF_BLTZ
    } xfer_e;

    typedef struct packed {
        path_e             path;
        logic              is_load;
        logic              use_rd;
        logic              use_imm;
        logic              traps;
        logic              sub;
        logic [SEL_W-1:0]  fcls;
        logic [SEL_W-1:0]  lfn;
        xfer_e             xfer;
    } dec_t;

    // Opcodes
    localparam logic [OP_W-1:0] OPC_RTYPE = 6'd0;
    localparam logic [OP_W-1:0] OPC_BLTZ  = 6'd1;
    localparam logic [OP_W-1:0] OPC_J     = 6'd2;
    localparam logic [OP_W-1:0] OPC_JAL   = 6'd3;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OP_W-1:0] OPC_BNE   = 6'd5;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OP_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OP_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OP_W-1:0] OPC_XORI  = 6'd14;
    localparam logic [OP_W-1:0] OPC_LUI   = 6'd15;
    localparam logic [OP_W-1:0] OPC_LW    = 6'd35;
    localparam logic [OP_W-1:0] OPC_SW    = 6'd43;

    // Function codes under opcode 0
    localparam logic [FN_W-1:0] FN_JR  = 6'd8;
    localparam logic [FN_W-1:0] FN_SYS = 6'd12;
    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB = 6'd34;
    localparam logic [FN_W-1:0] FN_AND = 6'd36;
    localparam logic [FN_W-1:0] FN_OR  = 6'd37;
    localparam logic [FN_W-1:0] FN_XOR = 6'd38;
    localparam logic [FN_W-1:0] FN_NOR = 6'd39;
    localparam logic [FN_W-1:0] FN_SLT = 6'd42;

    // Output encodings
    localparam logic [SEL_W-1:0] PCS_JADDR = 2'd0;
    localparam logic [SEL_W-1:0] PCS_XREG  = 2'd1;
    localparam logic [SEL_W-1:0] PCS_ZREG  = 2'd2;
    localparam logic [SEL_W-1:0] PCS_ALU   = 2'd3;
    localparam logic [SEL_W-1:0] JS_JTA    = 2'd0;
    localparam logic [SEL_W-1:0] JS_SYS    = 2'd1;
    localparam logic [SEL_W-1:0] JS_TRAP   = 2'd2;
    localparam logic [SEL_W-1:0] RD_RT     = 2'd0;
    localparam logic [SEL_W-1:0] RD_RD     = 2'd1;
    localparam logic [SEL_W-1:0] RD_R31    = 2'd2;
    localparam logic [SEL_W-1:0] RIS_DATA  = 2'd0;
    localparam logic [SEL_W-1:0] RIS_Z     = 2'd1;
    localparam logic [SEL_W-1:0] RIS_PC    = 2'd2;
    localparam logic [SEL_W-1:0] AY_FOUR   = 2'd0;
    localparam logic [SEL_W-1:0] AY_YREG   = 2'd1;
    localparam logic [SEL_W-1:0] AY_IMM    = 2'd2;
    localparam logic [SEL_W-1:0] AY_IMM4   = 2'd3;
    localparam logic [SEL_W-1:0] FC_LUI    = 2'd0;
    localparam logic [SEL_W-1:0] FC_SLT    = 2'd1;
    localparam logic [SEL_W-1:0] FC_ARITH  = 2'd2;
    localparam logic [SEL_W-1:0] FC_LOGIC  = 2'd3;
    localparam logic [SEL_W-1:0] LF_AND    = 2'd0;
    localparam logic [SEL_W-1:0] LF_OR     = 2'd1;
    localparam logic [SEL_W-1:0] LF_XOR    = 2'd2;
    localparam logic [SEL_W-1:0] LF_NOR    = 2'd3;

endpackage

// File: rtl/mc_op_decode.sv
// Instruction decoder: turns the opcode and function fields into the
// path the instruction takes and the ALU settings it needs.
// Purely combinational; assumes the fields are stable after fetch.
module mc_op_decode
    import mc_ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output dec_t            dec
);

    // Classify the instruction and select its ALU fields.
    always_comb begin
        dec      = '0;
        dec.path = PATH_BAD;
        dec.xfer = XF_J;
        case (opcode)
            OPC_RTYPE: begin
                dec.use_rd = 1'b1;
                case (funct)
                    FN_ADD: begin
                        dec.path  = PATH_ALU;
                        dec.traps = 1'b1;
                        dec.fcls  = FC_ARITH;
                    end
                    FN_SUB: begin
                        dec.path  = PATH_ALU;
                        dec.traps = 1'b1;
                        dec.sub   = 1'b1;
                        dec.fcls  = FC_ARITH;
                    end
                    FN_SLT: begin
                        dec.path = PATH_ALU;
                        dec.sub  = 1'b1;
                        dec.fcls = FC_SLT;
                    end
                    FN_AND: begin
                        dec.path = PATH_ALU;
                        dec.fcls = FC_LOGIC;
                        dec.lfn  = LF_AND;
                    end
                    FN_OR: begin
                        dec.path = PATH_ALU;
                        dec.fcls = FC_LOGIC;
                        dec.lfn  = LF_OR;
                    end
                    FN_XOR: begin
                        dec.path = PATH_ALU;
                        dec.fcls = FC_LOGIC;
                        dec.lfn  = LF_XOR;
                    end
                    FN_NOR: begin
                        dec.path = PATH_ALU;
                        dec.fcls = FC_LOGIC;
                        dec.lfn  = LF_NOR;
                    end
                    FN_JR: begin
                        dec.path = PATH_XFER;
                        dec.xfer = XF_JR;
                    end
                    FN_SYS: begin
                        dec.path = PATH_XFER;
                        dec.xfer = XF_SYS;
                    end
                    default: dec.path = PATH_BAD;
                endcase
            end
            OPC_LUI: begin
                dec.path    = PATH_ALU;
                dec.use_imm = 1'b1;
                dec.fcls    = FC_LUI;
            end
            OPC_ADDI: begin
                dec.path    = PATH_ALU;
                dec.use_imm = 1'b1;
                dec.traps   = 1'b1;
                dec.fcls    = FC_ARITH;
            end
            OPC_SLTI: begin
                dec.path    = PATH_ALU;
                dec.use_imm = 1'b1;
                dec.sub     = 1'b1;
                dec.fcls    = FC_SLT;
            end
            OPC_ANDI: begin
                dec.path    = PATH_ALU;
                dec.use_imm = 1'b1;
                dec.fcls    = FC_LOGIC;
                dec.lfn     = LF_AND;
            end
            OPC_ORI: begin
                dec.path    = PATH_ALU;
                dec.use_imm = 1'b1;
                dec.fcls    = FC_LOGIC;
                dec.lfn     = LF_OR;
            end
            OPC_XORI: begin
                dec.path    = PATH_ALU;
                dec.use_imm = 1'b1;
                dec.fcls    = FC_LOGIC;
                dec.lfn     = LF_XOR;
            end
            OPC_LW: begin
                dec.path    = PATH_MEM;
                dec.is_load = 1'b1;
            end
            OPC_SW:   dec.path = PATH_MEM;
            OPC_J: begin
                dec.path = PATH_XFER;
                dec.xfer = XF_J;
            end
            OPC_JAL: begin
                dec.path = PATH_XFER;
                dec.xfer = XF_JAL;
            end
            OPC_BEQ: begin
                dec.path = PATH_XFER;
                dec.xfer = XF_BEQ;
            end
            OPC_BNE: begin
                dec.path = PATH_XFER;
                dec.xfer = XF_BNE;
            end
            OPC_BLTZ: begin
                dec.path = PATH_XFER;
                dec.xfer = XF_BLTZ;
            end
            default: dec.path = PATH_BAD;
        endcase
    end

endmodule

// File: rtl/mc_state_seq.sv
// State sequencer: holds the control state and picks the next one from
// the decoded path, the load/store kind and the ALU overflow flag.
// Synchronous active-low reset to the fetch state.
module mc_state_seq
    import mc_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  dec_t   dec,
    input  logic   alu_ovf,
    output state_e state
);

    state_e nxt;

    // Next-state selection.
    always_comb begin
        case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (dec.path)
                    PATH_ALU:  nxt = ST_EXEC;
                    PATH_MEM:  nxt = ST_ADDR;
                    PATH_XFER: nxt = ST_XFER;
                    default:   nxt = ST_BADX;
                endcase
            end
            ST_ADDR:   nxt = dec.is_load ? ST_MRD : ST_MWR;
            ST_MRD:    nxt = ST_LDWB;
            ST_EXEC:   nxt = (dec.traps && alu_ovf) ? ST_OVFX : ST_ALUWB;
            default:   nxt = ST_FETCH;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= nxt;
    end

endmodule

// File: rtl/mc_ctrl_gen.sv
// Control output generator: drives every datapath select and enable from
// the current state, jointly with the decoded instruction in the execute,
// transfer and writeback states. Combinational.
module mc_ctrl_gen
    import mc_ctrl_pkg::*;
(
    input  state_e           state,
    input  dec_t             dec,
    input  logic             alu_zero,
    input  logic             alu_sign,
    output logic             pc_wr,
    output logic [SEL_W-1:0] pc_src,
    output logic [SEL_W-1:0] jmp_sel,
    output logic             inst_data,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             reg_wr,
    output logic [SEL_W-1:0] reg_dst,
    output logic [SEL_W-1:0] reg_in_src,
    output logic             alu_x_sel,
    output logic [SEL_W-1:0] alu_y_sel,
    output logic             add_sub,
    output logic [SEL_W-1:0] logic_fn,
    output logic [SEL_W-1:0] fn_class,
    output logic             epc_wr
);

    // Per-state control settings; all outputs idle unless set below.
    always_comb begin
        pc_wr      = 1'b0;
        pc_src     = PCS_JADDR;
        jmp_sel    = JS_JTA;
        inst_data  = 1'b0;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        ir_wr      = 1'b0;
        reg_wr     = 1'b0;
        reg_dst    = RD_RT;
        reg_in_src = RIS_DATA;
        alu_x_sel  = 1'b0;
        alu_y_sel  = AY_FOUR;
        add_sub    = 1'b0;
        logic_fn   = LF_AND;
        fn_class   = FC_LUI;
        epc_wr     = 1'b0;
        case (state)
            ST_FETCH: begin
                mem_rd   = 1'b1;
                ir_wr    = 1'b1;
                fn_class = FC_ARITH;
                pc_src   = PCS_ALU;
                pc_wr    = 1'b1;
            end
            ST_DECODE: begin
                alu_y_sel = AY_IMM4;
                fn_class  = FC_ARITH;
            end
            ST_ADDR: begin
                alu_x_sel = 1'b1;
                alu_y_sel = AY_IMM;
                fn_class  = FC_ARITH;
            end
            ST_MRD: begin
                inst_data = 1'b1;
                mem_rd    = 1'b1;
            end
            ST_LDWB: begin
                reg_wr     = 1'b1;
                reg_dst    = RD_RT;
                reg_in_src = RIS_DATA;
            end
            ST_MWR: begin
                inst_data = 1'b1;
                mem_wr    = 1'b1;
            end
            ST_XFER: begin
                alu_x_sel = 1'b1;
                alu_y_sel = AY_YREG;
                add_sub   = 1'b1;
                fn_class  = FC_ARITH;
                case (dec.xfer)
                    XF_J: begin
                        pc_src = PCS_JADDR;
                        pc_wr  = 1'b1;
                    end
                    XF_JAL: begin
                        pc_src     = PCS_JADDR;
                        pc_wr      = 1'b1;
                        reg_wr     = 1'b1;
                        reg_dst    = RD_R31;
                        reg_in_src = RIS_PC;
                    end
                    XF_JR: begin
                        pc_src = PCS_XREG;
                        pc_wr  = 1'b1;
                    end
                    XF_SYS: begin
                        pc_src  = PCS_JADDR;
                        jmp_sel = JS_SYS;
                        pc_wr   = 1'b1;
                    end
                    XF_BEQ: begin
                        pc_src = PCS_ZREG;
                        pc_wr  = alu_zero;
                    end
                    XF_BNE: begin
                        pc_src = PCS_ZREG;
                        pc_wr  = !alu_zero;
                    end
                    XF_BLTZ: begin
                        pc_src = PCS_ZREG;
                        pc_wr  = alu_sign;
                    end
                    default: pc_wr = 1'b0;
                endcase
            end
            ST_EXEC: begin
                alu_x_sel = 1'b1;
                alu_y_sel = dec.use_imm ? AY_IMM : AY_YREG;
                add_sub   = dec.sub;
                fn_class  = dec.fcls;
                logic_fn  = dec.lfn;
            end
            ST_ALUWB: begin
                reg_wr     = 1'b1;
                reg_in_src = RIS_Z;
                reg_dst    = dec.use_rd ? RD_RD : RD_RT;
            end
            ST_OVFX, ST_BADX: begin
                epc_wr  = 1'b1;
                pc_wr   = 1'b1;
                pc_src  = PCS_JADDR;
                jmp_sel = JS_TRAP;
            end
            default: pc_wr = 1'b0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
// Top of the multicycle control unit: decoder, state sequencer and output
// generator. Assumes opcode/funct come from the instruction register and
// the ALU flags are valid in the cycle that uses them.
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    input  logic [FN_W-1:0]  funct,
    input  logic             alu_zero,
    input  logic             alu_sign,
    input  logic             alu_ovf,
    output logic             pc_wr,
    output logic [SEL_W-1:0] pc_src,
    output logic [SEL_W-1:0] jmp_sel,
    output logic             inst_data,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             reg_wr,
    output logic [SEL_W-1:0] reg_dst,
    output logic [SEL_W-1:0] reg_in_src,
    output logic             alu_x_sel,
    output logic [SEL_W-1:0] alu_y_sel,
    output logic             add_sub,
    output logic [SEL_W-1:0] logic_fn,
    output logic [SEL_W-1:0] fn_class,
    output logic             epc_wr
);

    dec_t   dec;
    state_e state;

    mc_op_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .dec    (dec)
    );

    mc_state_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .alu_ovf (alu_ovf),
        .state   (state)
    );

    mc_ctrl_gen u_gen (
        .state      (state),
        .dec        (dec),
        .alu_zero   (alu_zero),
        .alu_sign   (alu_sign),
        .pc_wr      (pc_wr),
        .pc_src     (pc_src),
        .jmp_sel    (jmp_sel),
        .inst_data  (inst_data),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .ir_wr      (ir_wr),
        .reg_wr     (reg_wr),
        .reg_dst    (reg_dst),
        .reg_in_src (reg_in_src),
        .alu_x_sel  (alu_x_sel),
        .alu_y_sel  (alu_y_sel),
        .add_sub    (add_sub),
        .logic_fn   (logic_fn),
        .fn_class   (fn_class),
        .epc_wr     (epc_wr)
    );

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
// Checker for the control unit: temporal properties over its ports,
// bound to every instance of mc_ctrl_fsm.
module mc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pc_wr,
    input logic [1:0] pc_src,
    input logic [1:0] jmp_sel,
    input logic       inst_data,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       reg_wr,
    input logic [1:0] reg_in_src,
    input logic       epc_wr
);

    AST_FETCH_READS_BY_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |-> (mem_rd && !inst_data && pc_wr)); // R2
    AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> !ir_wr); // R3
    AST_MEM_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R11
    AST_LOAD_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && inst_data) |=> (reg_wr && reg_in_src == 2'd0)); // R4
    AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ir_wr); // R4
    AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> ir_wr); // R8
    AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr |-> (pc_wr && pc_src == 2'd0 && jmp_sel == 2'd2)); // R9
    AST_TRAP_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr |=> ir_wr); // R9

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_wr      (pc_wr),
    .pc_src     (pc_src),
    .jmp_sel    (jmp_sel),
    .inst_data  (inst_data),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ir_wr      (ir_wr),
    .reg_wr     (reg_wr),
    .reg_in_src (reg_in_src),
    .epc_wr     (epc_wr)
);

// File: tb/mc_ctrl_fsm_test.sv
// Bench: behavioural state model compared with every output on every cycle.
module mc_ctrl_fsm_test;

    localparam int CLK_PERIOD = 10;
    localparam int NPROG      = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       alu_zero = 1'b0;
    logic       alu_sign = 1'b0;
    logic       alu_ovf = 1'b0;
    logic       pc_wr, inst_data, mem_rd, mem_wr, ir_wr, reg_wr, alu_x_sel, add_sub, epc_wr;
    logic [1:0] pc_src, jmp_sel, reg_dst, reg_in_src, alu_y_sel, logic_fn, fn_class;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // expected outputs
    int e_pc_wr, e_pc_src, e_jmp, e_inst, e_mrd, e_mwr, e_irw, e_rw, e_rdst, e_rin;
    int e_ax, e_ay, e_as, e_lf, e_fc, e_epc;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_ctrl_fsm uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
        .alu_zero(alu_zero), .alu_sign(alu_sign), .alu_ovf(alu_ovf),
        .pc_wr(pc_wr), .pc_src(pc_src), .jmp_sel(jmp_sel), .inst_data(inst_data),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
        .reg_dst(reg_dst), .reg_in_src(reg_in_src), .alu_x_sel(alu_x_sel),
        .alu_y_sel(alu_y_sel), .add_sub(add_sub), .logic_fn(logic_fn),
        .fn_class(fn_class), .epc_wr(epc_wr)
    );

    task automatic chk(input string tag, input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d time=%0t", tag, name, act, exp, $time);
        end
    endtask

    function automatic bit is_ralu(input int op, input int fn);
        return op == 0 && (fn == 32 || fn == 34 || fn == 42 || fn == 36 || fn == 37 || fn == 38 || fn == 39);
    endfunction
    function automatic bit is_ialu(input int op);
        return op == 15 || op == 8 || op == 10 || op == 12 || op == 13 || op == 14;
    endfunction
    function automatic bit is_xfer(input int op, input int fn);
        return (op >= 1 && op <= 5) || (op == 0 && (fn == 8 || fn == 12));
    endfunction
    function automatic bit is_trap(input int op, input int fn);
        return (op == 0 && (fn == 32 || fn == 34)) || op == 8;
    endfunction
    // 0 alu, 1 mem, 2 transfer, 3 undefined
    function automatic int path_of(input int op, input int fn);
        if (is_ralu(op, fn) || is_ialu(op)) return 0;
        if (op == 35 || op == 43) return 1;
        if (is_xfer(op, fn)) return 2;
        return 3;
    endfunction

    function automatic int model_next(input int st, input int op, input int fn, input bit ov);
        case (st)
            0: return 1;
            1: begin
                case (path_of(op, fn))
                    0: return 7;
                    1: return 2;
                    2: return 5;
                    default: return 10;
                endcase
            end
            2: return (op == 35) ? 3 : 6;
            3: return 4;
            7: return (is_trap(op, fn) && ov) ? 9 : 8;
            default: return 0;
        endcase
    endfunction

    task automatic model_out(input int st, input int op, input int fn, input bit z, input bit s);
        e_pc_wr = 0; e_pc_src = 0; e_jmp = 0; e_inst = 0; e_mrd = 0; e_mwr = 0; e_irw = 0;
        e_rw = 0; e_rdst = 0; e_rin = 0; e_ax = 0; e_ay = 0; e_as = 0; e_lf = 0; e_fc = 0; e_epc = 0;
        case (st)
            0: begin e_mrd = 1; e_irw = 1; e_fc = 2; e_pc_src = 3; e_pc_wr = 1; end
            1: begin e_ay = 3; e_fc = 2; end
            2: begin e_ax = 1; e_ay = 2; e_fc = 2; end
            3: begin e_inst = 1; e_mrd = 1; end
            4: begin e_rw = 1; end
            6: begin e_inst = 1; e_mwr = 1; end
            5: begin
                e_ax = 1; e_ay = 1; e_as = 1; e_fc = 2;
                if (op == 2) e_pc_wr = 1;
                else if (op == 3) begin e_pc_wr = 1; e_rw = 1; e_rdst = 2; e_rin = 2; end
                else if (op == 0 && fn == 8) begin e_pc_src = 1; e_pc_wr = 1; end
                else if (op == 0 && fn == 12) begin e_jmp = 1; e_pc_wr = 1; end
                else if (op == 4) begin e_pc_src = 2; e_pc_wr = z; end
                else if (op == 5) begin e_pc_src = 2; e_pc_wr = !z; end
                else if (op == 1) begin e_pc_src = 2; e_pc_wr = s; end
            end
            7: begin
                e_ax = 1;
                e_ay = (op == 0) ? 1 : 2;
                e_as = ((op == 0 && (fn == 34 || fn == 42)) || op == 10) ? 1 : 0;
                if (op == 15) e_fc = 0;
                else if ((op == 0 && fn == 42) || op == 10) e_fc = 1;
                else if ((op == 0 && (fn == 32 || fn == 34)) || op == 8) e_fc = 2;
                else e_fc = 3;
                if ((op == 0 && fn == 37) || op == 13) e_lf = 1;
                else if ((op == 0 && fn == 38) || op == 14) e_lf = 2;
                else if (op == 0 && fn == 39) e_lf = 3;
            end
            8: begin e_rw = 1; e_rin = 1; e_rdst = (op == 0) ? 1 : 0; end
            9, 10: begin e_epc = 1; e_pc_wr = 1; e_jmp = 2; end
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int st);
        case (st)
            0: return "R2";
            1: return "R3";
            2, 3, 4, 6: return "R4";
            5: return "R5";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic compare_all(input string t);
        chk(t, "pc_wr", int'(pc_wr), e_pc_wr);
        chk(t, "pc_src", int'(pc_src), e_pc_src);
        chk(t, "jmp_sel", int'(jmp_sel), e_jmp);
        chk(t, "inst_data", int'(inst_data), e_inst);
        chk(t, "mem_rd", int'(mem_rd), e_mrd);
        chk(t, "mem_wr", int'(mem_wr), e_mwr);
        chk(t, "ir_wr", int'(ir_wr), e_irw);
        chk(t, "reg_wr", int'(reg_wr), e_rw);
        chk(t, "reg_dst", int'(reg_dst), e_rdst);
        chk(t, "reg_in_src", int'(reg_in_src), e_rin);
        chk(t, "alu_x_sel", int'(alu_x_sel), e_ax);
        chk(t, "alu_y_sel", int'(alu_y_sel), e_ay);
        chk(t, "add_sub", int'(add_sub), e_as);
        chk(t, "logic_fn", int'(logic_fn), e_lf);
        chk(t, "fn_class", int'(fn_class), e_fc);
        chk(t, "epc_wr", int'(epc_wr), e_epc);
    endtask

    // Run one instruction from fetch back to fetch; called just after a falling edge.
    task automatic run_instr(input int op, input int fn, input bit z, input bit s, input bit ov);
        int st = 0;
        int cnt = 0;
        int rw_cnt = 0;
        int mw_cnt = 0;
        int exp_cnt;
        int exp_rw;
        opcode = 6'(op); funct = 6'(fn); alu_zero = z; alu_sign = s; alu_ovf = ov;
        do begin
            #1;
            model_out(st, op, fn, z, s);
            compare_all(tag_of(st));
            if (reg_wr) rw_cnt++;
            if (mem_wr) mw_cnt++;
            cnt++;
            st = model_next(st, op, fn, ov);
            @(negedge clk);
        end while (st != 0 && cnt < 20);
        case (path_of(op, fn))
            0: exp_cnt = 4;
            1: exp_cnt = (op == 35) ? 5 : 4;
            2: exp_cnt = 3;
            default: exp_cnt = 3;
        endcase
        chk("R6", "cycles", cnt, exp_cnt);
        exp_rw = 0;
        if (op == 35 || op == 3) exp_rw = 1;
        if (path_of(op, fn) == 0 && !(is_trap(op, fn) && ov)) exp_rw = 1;
        // R9 / R10 / R11: no write for a trapped or undefined instruction
        chk(path_of(op, fn) == 3 ? "R10" : "R11", "reg_wr count", rw_cnt, exp_rw);
        chk("R11", "mem_wr count", mw_cnt, (op == 43) ? 1 : 0);
    endtask

    int prog_op [NPROG] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                            15, 8, 10, 12, 13, 14, 35, 43, 2, 3, 1, 4, 5, 6, 63};
    int prog_fn [NPROG] = '{32, 34, 42, 36, 37, 38, 39, 8, 12, 0,
                            0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1: fetch controls while reset is held
        chk("R1", "pc_wr", int'(pc_wr), 1);
        chk("R1", "pc_src", int'(pc_src), 3);
        chk("R1", "mem_rd", int'(mem_rd), 1);
        chk("R1", "ir_wr", int'(ir_wr), 1);
        chk("R1", "reg_wr", int'(reg_wr), 0);
        chk("R1", "mem_wr", int'(mem_wr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int pass = 0; pass < 4; pass++) begin
            for (int i = 0; i < NPROG; i++) begin
                run_instr(prog_op[i], prog_fn[i], pass[0], pass[1], (pass == 1 || pass == 2));
            end
        end
        // R1: reset in mid-instruction returns to fetch
        opcode = 6'd35; funct = 6'd0; alu_ovf = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R1", "ir_wr after reset", int'(ir_wr), 1);
        chk("R1", "mem_wr after reset", int'(mem_wr), 0);
        chk("R1", "reg_wr after reset", int'(reg_wr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_instr(35, 0, 1'b0, 1'b0, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule